// File: doc/BRIEF.md
# Port Pin-Interrupt Edge Controller

This block serves one eight-pin general-purpose port. For each pin it holds a direction bit, a pull-enable bit, a polarity bit, an interrupt-enable bit and a sticky interrupt flag. Each pin is brought into the clock domain through two flip-flops. A synchronized transition in the direction that the polarity bit selects sets that pin's flag, but only while the pin is an input.

The interrupt request is a registered OR of every flag whose enable bit is set. The polarity bit has a second job. It also chooses which pull device the pin uses: pull-up for 0, pull-down for 1. The block drives digital pull-up and pull-down controls for the pad. A control is active only while the pin is an input with its pull enabled.

Software reaches the registers through a single-cycle bus with an address, a write strobe, write data and combinational read data. Flags are cleared by writing 1 to their bits.

Top module: `pin_irq_ctrl`

## Requirements
- R1: After reset, every register reads 0, both pull control outputs are 0 and the interrupt request is 0.
- R2: Direction (address 0, bit 1 = output), pull enable (address 1), polarity (address 2) and interrupt enable (address 3) can be written at any time and read back unchanged. Addresses 5 to 7 read 0, and a write to them changes no register.
- R3: With polarity bit 0, a falling edge on an input pin sets that pin's flag (address 4, bit i for pin i), and a rising edge does not.
- R4: With polarity bit 1, a rising edge on an input pin sets its flag, and a falling edge does not.
- R5: A pin whose direction bit is 1 never sets its flag, whatever its level changes.
- R6: Writing 1 to a flag bit at address 4 clears it. Writing 0 leaves it unchanged.
- R7: If an edge sets a flag in the same cycle that a write clears it, the flag stays set.
- R8: A flag is set whether or not its enable bit is set. The interrupt request is high exactly one clock after some flag and its enable bit are both high, so enabling a pin whose flag is already set raises the request.
- R9: Pull-up output bit i is 1 exactly when pin i is an input, its pull enable is 1 and its polarity is 0. Pull-down output bit i is 1 exactly when pin i is an input, its pull enable is 1 and its polarity is 1.
- R10: A pin change presented before clock edge k appears in the flag register after edge k+2 and in the interrupt request after edge k+3. Before those edges, the flag and the request are still low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_i | input | 8 | Port pin levels, asynchronous |
| reg_addr | input | 3 | Register address |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| pull_up_o | output | 8 | Per-pin pull-up control |
| pull_dn_o | output | 8 | Per-pin pull-down control |
| irq_o | output | 1 | Interrupt request |

## Verification
A flag that is lost or set by mistake shows at address 4 three clocks after the pin change, and on the request one clock after that. Because the bench reads at exactly those edges, a wrong synchronizer depth shows up as a flag that arrives a cycle early or late. A polarity bit that is wrongly stored shows at once on the pull outputs, since those are combinational from the registers. It also shows on the next edge, because the wrong direction of transition then sets the flag. A broken clear or a broken mask shows on the next read of the flags or on the request one clock later.

// File: rtl/pin_irq_ctrl.sv
module pin_irq_ctrl #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_i,
  input  logic [2:0]   reg_addr,
  input  logic         reg_we,
  input  logic [N-1:0] reg_wdata,
  output logic [N-1:0] reg_rdata,
  output logic [N-1:0] pull_up_o,
  output logic [N-1:0] pull_dn_o,
  output logic         irq_o
);
  localparam logic [2:0] A_DIR = 3'd0, A_PEN = 3'd1, A_POL = 3'd2,
                         A_IEN = 3'd3, A_FLG = 3'd4;

  logic [N-1:0] dir, pen, pol, ien, flag;
  logic [N-1:0] meta, sync, prev;
  logic [N-1:0] rise, fall, hit, clr;

  assign rise = sync & ~prev;
  assign fall = ~sync & prev;
  assign hit  = ~dir & ((pol & rise) | (~pol & fall));
  assign clr  = (reg_we && reg_addr == A_FLG) ? reg_wdata : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      meta <= '0;
      sync <= '0;
      prev <= '0;
    end else begin
      meta <= pin_i;
      sync <= meta;
      prev <= sync;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      dir <= '0;
      pen <= '0;
      pol <= '0;
      ien <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        A_DIR:   dir <= reg_wdata;
        A_PEN:   pen <= reg_wdata;
        A_POL:   pol <= reg_wdata;
        A_IEN:   ien <= reg_wdata;
        default: ;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) flag <= '0;
    else        flag <= (flag & ~clr) | hit;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= |(flag & ien);

  always_comb
    case (reg_addr)
      A_DIR:   reg_rdata = dir;
      A_PEN:   reg_rdata = pen;
      A_POL:   reg_rdata = pol;
      A_IEN:   reg_rdata = ien;
      A_FLG:   reg_rdata = flag;
      default: reg_rdata = '0;
    endcase

  assign pull_up_o = ~dir & pen & ~pol;
  assign pull_dn_o = ~dir & pen & pol;
endmodule

module pin_irq_ctrl_chk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] dir,
  input logic [N-1:0] pen,
  input logic [N-1:0] ien,
  input logic [N-1:0] flag,
  input logic [N-1:0] clr,
  input logic [N-1:0] pull_up_o,
  input logic [N-1:0] pull_dn_o,
  input logic         irq_o
);
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(flag) & ~$past(clr) & ~flag) == '0)); // R6
  AST_OUTPUT_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(dir) & flag & ~$past(flag)) == '0)); // R5
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o == |($past(flag) & $past(ien)))); // R8
  AST_PULL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    ((pull_up_o & pull_dn_o) == '0)); // R9
  AST_PULL_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (((pull_up_o | pull_dn_o) & (dir | ~pen)) == '0)); // R9
endmodule

bind pin_irq_ctrl pin_irq_ctrl_chk #(.N(N)) chk (
  .clk(clk), .rst_n(rst_n), .dir(dir), .pen(pen), .ien(ien), .flag(flag),
  .clr(clr), .pull_up_o(pull_up_o), .pull_dn_o(pull_dn_o), .irq_o(irq_o));

// File: tb/pin_irq_ctrl_test.sv
module pin_irq_ctrl_test;
  localparam int PERIOD = 10;
  logic clk = 0, rst_n = 0, reg_we = 0;
  logic [7:0] pin_i = 0, reg_wdata = 0, reg_rdata, pull_up_o, pull_dn_o;
  logic [2:0] reg_addr = 0;
  logic irq_o;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  pin_irq_ctrl uut (.clk(clk), .rst_n(rst_n), .pin_i(pin_i), .reg_addr(reg_addr),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pull_up_o(pull_up_o), .pull_dn_o(pull_dn_o), .irq_o(irq_o));

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic settle(); repeat (4) @(negedge clk); endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD*200000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    for (int a = 0; a < 8; a++) begin rd(a[2:0], d); chk("R1 reg", d, 8'h00); end
    chk("R1 pullup", pull_up_o, 0); chk("R1 pulldn", pull_dn_o, 0);
    chk("R1 irq", {7'd0, irq_o}, 0);
    rst_n = 1;

    for (int v = 0; v < 256; v++) begin
      logic [7:0] dv, pv, lv;
      dv = v[7:0]; pv = ~{v[3:0], v[7:4]}; lv = v[7:0] ^ 8'h5A;
      wr(0, dv); wr(1, pv); wr(2, lv); wr(3, ~lv);
      rd(0, d); chk("R2 dir", d, dv);
      rd(1, d); chk("R2 pen", d, pv);
      rd(2, d); chk("R2 pol", d, lv);
      rd(3, d); chk("R2 ien", d, ~lv);
      chk("R9 pullup", pull_up_o, ~dv & pv & ~lv);
      chk("R9 pulldn", pull_dn_o, ~dv & pv & lv);
    end
    wr(0, 8'h11); wr(1, 8'h22); wr(2, 8'h33); wr(3, 8'h00);
    for (int a = 5; a < 8; a++) begin
      wr(a[2:0], 8'hFF); rd(a[2:0], d); chk("R2 unmapped read", d, 0);
    end
    rd(0, d); chk("R2 dir kept", d, 8'h11);
    rd(1, d); chk("R2 pen kept", d, 8'h22);
    rd(2, d); chk("R2 pol kept", d, 8'h33);

    for (int i = 0; i < 8; i++)
      for (int p = 0; p < 2; p++)
        for (int o = 0; o < 2; o++)
          for (int s = 0; s < 2; s++) begin
            logic [7:0] m, e;
            logic hit;
            m = 8'(1 << i);
            wr(0, o ? m : 8'h00); wr(2, p ? m : 8'h00); wr(3, 8'h00);
            @(negedge clk); pin_i = s ? m : 8'h00;
            settle(); wr(4, 8'hFF); settle();
            @(negedge clk); pin_i = s ? 8'h00 : m;
            settle();
            hit = (o == 0) && ((p == 1) == (s == 0));
            e = hit ? m : 8'h00;
            rd(4, d);
            if (o) chk("R5 output pin", d, e);
            else if (p) chk("R4 rising", d, e);
            else chk("R3 falling", d, e);
            chk("R8 masked irq", {7'd0, irq_o}, 0);
            wr(3, 8'hFF); @(negedge clk);
            chk("R8 enable later", {7'd0, irq_o}, {7'd0, hit});
            wr(4, 8'hFF); @(negedge clk); pin_i = 0; settle(); wr(4, 8'hFF);
          end

    wr(0, 0); wr(2, 0); wr(3, 8'h01); @(negedge clk); pin_i = 8'h01; settle(); wr(4, 8'hFF);
    settle();
    @(negedge clk); pin_i = 8'h00;
    @(negedge clk); rd(4, d); chk("R10 after 1 edge", d, 0);
    @(negedge clk); rd(4, d); chk("R10 after 2 edges", d, 0);
    @(negedge clk); rd(4, d); chk("R10 flag after 3 edges", d, 8'h01);
    chk("R10 irq not yet", {7'd0, irq_o}, 0);
    @(negedge clk); chk("R10 irq after 4 edges", {7'd0, irq_o}, 1);

    wr(4, 8'h00); rd(4, d); chk("R6 write 0 keeps", d, 8'h01);
    wr(4, 8'h01); rd(4, d); chk("R6 write 1 clears", d, 8'h00);
    @(negedge clk); chk("R8 irq drops", {7'd0, irq_o}, 0);

    pin_i = 8'h01; settle(); wr(4, 8'hFF);
    @(negedge clk); pin_i = 8'h00; settle(); rd(4, d); chk("R3 prep", d, 8'h01);
    pin_i = 8'h01; settle();
    pin_i = 8'h00;
    @(posedge clk); @(posedge clk);
    @(negedge clk); reg_addr = 4; reg_wdata = 8'h01; reg_we = 1;
    @(negedge clk); reg_we = 0;
    rd(4, d); chk("R7 set wins over clear", d, 8'h01);
    wr(4, 8'h01); rd(4, d); chk("R6 clear after", d, 8'h00);

    summary();
  end
endmodule